// File: doc/BRIEF.md
# Priority Reference Source Selector

This block picks one clock reference out of a set of candidate inputs (14 by default) for a downstream timing loop. Each candidate has a 4-bit priority written through a small register port. Each candidate also has four status flags supplied by external monitors: no activity, coarse frequency out of band, phase alarm, and outside the loop's lock range. From these the block keeps a qualified or disqualified state for every candidate. It always selects the best qualified one.

Which flags disqualify a candidate depends on whether it is currently in use. A standby candidate is dropped only for inactivity or an out-of-band frequency result. The candidate in use is also dropped for a phase alarm or for leaving the lock range. After such a drop, the block moves by itself to the next best qualified candidate. If no candidate is left, it raises a holdover request. It outputs the chosen index, a valid flag and a one-cycle switch pulse.

Top module: `ref_select`

## Requirements
- R1: After reset, sel_valid_o is 0, holdover_o is 1, switch_o is 0 and sel_idx_o is 0. Every priority register starts at 0.
- R2: When reg_we_i is high at a clock edge, reg_wdata_i is stored as the priority of input reg_addr_i. Writes to addresses 14 and 15 have no effect.
- R3: Priority 1 is the highest and 15 the lowest. An input with priority 0 is never selected.
- R4: Among qualified inputs of equal priority, the one with the lower index is selected.
- R5: An input that is not selected is disqualified only by inactivity (inact_i) or frequency out of band (freq_oob_i). Its phase_alm_i and lock_out_i bits have no effect.
- R6: The selected input is disqualified by any of its four flags. The block then selects the best remaining qualified input.
- R7: An input dropped while selected because of phase_alm_i or lock_out_i stays disqualified until both of those bits are low. It requalifies in the cycle after the low values are registered, so the selection returns three edges after the bits are cleared.
- R8: The selection is always the best qualified input. A better input that becomes qualified takes over from the current one.
- R9: With no qualified input, sel_valid_o is 0 and holdover_o is 1, and sel_idx_o keeps its last value.
- R10: switch_o is high for exactly one cycle, in the cycle where sel_idx_o changes while valid or where sel_valid_o rises. Dropping into holdover gives no pulse.
- R11: Flags are registered at one clock edge and act on the selection at the next edge. A priority write acts on the selection at the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | 4 | Input index whose priority is written |
| reg_wdata_i | input | 4 | Priority value (0 = never, 1 = highest) |
| inact_i | input | 14 | Per-input inactivity alarm |
| freq_oob_i | input | 14 | Per-input frequency out-of-band alarm |
| phase_alm_i | input | 14 | Per-input phase alarm |
| lock_out_i | input | 14 | Per-input outside-lock-range flag |
| sel_idx_o | output | 4 | Selected input index |
| sel_valid_o | output | 1 | A qualified input is selected |
| switch_o | output | 1 | One-cycle pulse on a change of selection |
| holdover_o | output | 1 | No qualified input; holdover requested |

## Verification
The hardest case to reach from the ports is the sticky disqualification of R7. It needs an input that is first selected and then loses that role through a phase or lock flag. After that, the same flag must be shown to be ignored while the input is on standby, and the input must come back once the flag clears. The stimulus first makes a standby input win a tie. It then raises a phase alarm on that input and holds the alarm, to show the selection does not bounce back. Finally it clears the alarm and expects the return exactly three edges later. A similar sequence with a lock-range flag runs while every other input is inactive, so the same path also passes through holdover.

// File: rtl/ref_select_pkg.sv
package ref_select_pkg;
  parameter int unsigned N_SRC  = 14;
  parameter int unsigned PRIO_W = 4;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             valid;
  } sel_t;
endpackage

// File: rtl/ref_prio_regs.sv
module ref_prio_regs #(
  parameter int unsigned N  = 14,
  parameter int unsigned PW = 4,
  parameter int unsigned AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [PW-1:0]         wdata_i,
  output logic [N-1:0][PW-1:0]  prio_o
);
  logic [N-1:0][PW-1:0] prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prio_q <= '0;
    else if (we_i && (32'(addr_i) < N)) prio_q[addr_i] <= wdata_i;
  end

  assign prio_o = prio_q;

  // R2: out-of-range writes leave every priority untouched
  a_r2_bad_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(addr_i) >= N)) |=> $stable(prio_q));
endmodule

// File: rtl/ref_qual.sv
module ref_qual #(
  parameter int unsigned N  = 14,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic [N-1:0]         inact_i,
  input  logic [N-1:0]         freq_oob_i,
  input  logic [N-1:0]         phase_alm_i,
  input  logic [N-1:0]         lock_out_i,
  input  logic [IW-1:0]        sel_idx_i,
  input  logic                 sel_valid_i,
  output logic [N-1:0]         qual_o
);
  logic [N-1:0] in_q, fr_q, ph_q, lk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0; fr_q <= '0; ph_q <= '0; lk_q <= '0;
    end else begin
      in_q <= inact_i; fr_q <= freq_oob_i; ph_q <= phase_alm_i; lk_q <= lock_out_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic is_sel, sel_fault, dq_q;

    assign is_sel    = sel_valid_i && (sel_idx_i == IW'(i));
    assign sel_fault = ph_q[i] || lk_q[i];

    // sticky drop: set while selected and faulted, released once both faults clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                dq_q <= 1'b0;
      else if (is_sel && sel_fault) dq_q <= 1'b1;
      else if (!sel_fault)        dq_q <= 1'b0;
    end

    assign qual_o[i] = (prio_i[i] != '0) && !in_q[i] && !fr_q[i] && !dq_q
                       && !(is_sel && sel_fault);

    // R7: a sticky drop survives while a fault remains
    a_r7_dq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dq_q && sel_fault) |=> dq_q);
  end
endmodule

// File: rtl/ref_pick.sv
module ref_pick #(
  parameter int unsigned N  = 14,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic [N-1:0]         qual_i,
  output logic [IW-1:0]        best_idx_o,
  output logic                 best_valid_o
);
  logic [PW-1:0] best_p;

  always_comb begin
    best_idx_o   = '0;
    best_valid_o = 1'b0;
    best_p       = '1;
    for (int j = 0; j < int'(N); j++) begin
      // strict compare keeps the lower index on ties
      if (qual_i[j] && (!best_valid_o || prio_i[j] < best_p)) begin
        best_idx_o   = IW'(j);
        best_p       = prio_i[j];
        best_valid_o = 1'b1;
      end
    end
  end

  // R3: a chosen input is qualified and has a nonzero priority
  a_r3_pick_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_valid_o |-> (qual_i[best_idx_o] && prio_i[best_idx_o] != '0));

  // R9: no pick only when nothing is qualified
  a_r9_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !best_valid_o |-> (qual_i == '0));

  for (genvar j = 0; j < N; j++) begin : g_chk
    // R8: no qualified input beats the pick
    a_r8_no_better: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (best_valid_o && qual_i[j]) |-> (prio_i[j] >= prio_i[best_idx_o]));
  end
endmodule

// File: rtl/ref_select.sv
module ref_select
  import ref_select_pkg::*;
#(
  parameter int unsigned N  = N_SRC,
  parameter int unsigned PW = PRIO_W,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [IW-1:0] reg_addr_i,
  input  logic [PW-1:0] reg_wdata_i,
  input  logic [N-1:0]  inact_i,
  input  logic [N-1:0]  freq_oob_i,
  input  logic [N-1:0]  phase_alm_i,
  input  logic [N-1:0]  lock_out_i,
  output logic [IW-1:0] sel_idx_o,
  output logic          sel_valid_o,
  output logic          switch_o,
  output logic          holdover_o
);
  logic [N-1:0][PW-1:0] prio;
  logic [N-1:0]         qual;
  logic [IW-1:0]        best_idx;
  logic                 best_valid;
  logic [IW-1:0]        sel_idx_q;
  logic                 sel_valid_q, switch_q;

  ref_prio_regs #(.N(N), .PW(PW), .AW(IW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .prio_o(prio)
  );

  ref_qual #(.N(N), .PW(PW), .IW(IW)) u_qual (
    .clk_i, .rst_ni, .prio_i(prio), .inact_i, .freq_oob_i, .phase_alm_i,
    .lock_out_i, .sel_idx_i(sel_idx_q), .sel_valid_i(sel_valid_q), .qual_o(qual)
  );

  ref_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
    .clk_i, .rst_ni, .prio_i(prio), .qual_i(qual),
    .best_idx_o(best_idx), .best_valid_o(best_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_idx_q   <= '0;
      sel_valid_q <= 1'b0;
      switch_q    <= 1'b0;
    end else begin
      sel_valid_q <= best_valid;
      switch_q    <= best_valid && (!sel_valid_q || best_idx != sel_idx_q);
      if (best_valid) sel_idx_q <= best_idx;
    end
  end

  assign sel_idx_o   = sel_idx_q;
  assign sel_valid_o = sel_valid_q;
  assign switch_o    = switch_q;
  assign holdover_o  = !sel_valid_q;

  // R10: a pulse only accompanies a valid, changed selection
  a_r10_switch_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> sel_valid_o);
  a_r10_switch_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> (!$past(sel_valid_o) || $past(sel_idx_o) != sel_idx_o));

  // R9: index frozen during holdover
  a_r9_idx_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holdover_o && $past(holdover_o)) |-> $stable(sel_idx_o));
endmodule

// File: tb/ref_select_test.sv
module ref_select_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [3:0]  reg_wdata = '0;
  logic [13:0] inact = '0, oob = '0, ph = '0, lk = '0;
  logic [3:0]  sel_idx;
  logic        sel_valid, sw, hold;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [3:0] idx;
    logic       v;
    logic       s;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ref_select uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .inact_i(inact), .freq_oob_i(oob),
    .phase_alm_i(ph), .lock_out_i(lk), .sel_idx_o(sel_idx),
    .sel_valid_o(sel_valid), .switch_o(sw), .holdover_o(hold)
  );

  task automatic check(string tag, logic [3:0] ei, logic ev, logic es);
    n_chk++;
    if (sel_idx !== ei || sel_valid !== ev || sw !== es || hold !== !ev) begin
      n_fail++;
      $display("FAIL %s: idx/valid/switch/hold got %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
               tag, sel_idx, sel_valid, sw, hold, ei, ev, es, !ev);
    end
  endtask

  // monitor: compare queued expectations in their target cycle
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.idx, e.v, e.s);
    end
  end

  // driver side: expected result d edges on, then a quiet cycle
  task automatic expect_sel(int d, logic [3:0] idx, logic v, logic s, string tag);
    sb.push_back('{at: cyc + d,     idx: idx, v: v, s: s,    tag: tag});
    sb.push_back('{at: cyc + d + 1, idx: idx, v: v, s: 1'b0, tag: {tag, " settle"}});
    repeat (d + 2) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] p);
    reg_we = 1'b1; reg_addr = a; reg_wdata = p;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 4'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 all priorities zero", 4'd0, 1'b0, 1'b0);

    wr(4'd5, 4'd3);  expect_sel(1, 4'd5, 1, 1, "R2 R11 first write selects 5");
    wr(4'd9, 4'd2);  expect_sel(1, 4'd9, 1, 1, "R8 better source 9 takes over");
    wr(4'd2, 4'd2);  expect_sel(1, 4'd2, 1, 1, "R4 tie goes to lower index 2");

    ph[9] = 1'b1;    expect_sel(2, 4'd2, 1, 0, "R5 phase on standby ignored");
    lk[5] = 1'b1;    expect_sel(2, 4'd2, 1, 0, "R5 lock on standby ignored");
    ph[9] = 1'b0; lk[5] = 1'b0;
                     expect_sel(2, 4'd2, 1, 0, "R5 clear standby flags");

    ph[2] = 1'b1;    expect_sel(2, 4'd9, 1, 1, "R6 R11 phase on selected drops to 9");
    repeat (4) @(negedge clk);
    check("R7 dropped source stays out", 4'd9, 1'b1, 1'b0);
    ph[2] = 1'b0;    expect_sel(3, 4'd2, 1, 1, "R7 returns after phase clears");

    inact[2] = 1'b1; expect_sel(2, 4'd9, 1, 1, "R6 inactivity on selected");
    inact[9] = 1'b1; expect_sel(2, 4'd5, 1, 1, "R6 next best is 5");
    oob[5] = 1'b1;   expect_sel(2, 4'd5, 0, 0, "R9 R10 holdover, no pulse");
    oob[5] = 1'b0;   expect_sel(2, 4'd5, 1, 1, "R10 valid rises with pulse");
    lk[5] = 1'b1;    expect_sel(2, 4'd5, 0, 0, "R6 R9 lock drop into holdover");
    lk[5] = 1'b0;    expect_sel(3, 4'd5, 1, 1, "R7 lock clears, 5 back");

    wr(4'd14, 4'd1); expect_sel(1, 4'd5, 1, 0, "R2 address 14 ignored");
    wr(4'd15, 4'd1); expect_sel(1, 4'd5, 1, 0, "R2 address 15 ignored");
    wr(4'd13, 4'd1); expect_sel(1, 4'd13, 1, 1, "R3 priority 1 wins");
    wr(4'd13, 4'd0); expect_sel(1, 4'd5, 1, 1, "R3 priority 0 never selected");
    inact[2] = 1'b0; expect_sel(2, 4'd2, 1, 1, "R8 source 2 requalifies");
    inact[9] = 1'b0; expect_sel(2, 4'd2, 1, 0, "R4 tie keeps index 2");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule